// File: doc/BRIEF.md
# Compare Flags and Branch Resolver

This block holds the relational status of a small processor core and settles every conditional or unconditional jump. A compare instruction weighs two 32-bit operands as signed two's-complement numbers and leaves exactly one of three flags set: equal, greater-than or less-than. The flags then stay unchanged until the next compare.

For any of the seven jump opcodes, the block tests the flag or flag pair that the opcode names. It then registers a taken bit and the next program counter. A taken jump goes either to a base register plus an offset or to a direct address, and a mode input picks which one. A jump that is not taken falls through to PC+4.

Fetch, flushing and interrupt entry live elsewhere. The block only reports where the next fetch should come from.

Top module: `branchResolver`

## Requirements
- R1: While reset is low, and on the first clock after reset, `flags` is 000, and `resValid`, `taken` and `nextPc` are all zero.
- R2: A valid opcode 0x14 updates `flags` at the next clock edge from a signed comparison of `srcA` with `srcB`. Bit 0 is equal, bit 1 is srcA greater, bit 2 is srcA less, and exactly one bit is set.
- R3: `flags` does not change for a cycle without a valid 0x14. This covers other opcodes and a 0x14 with `instValid` low.
- R4: Opcode 0x0D is taken whatever the flags hold.
- R5: Opcode 0x0E is taken when equal is set, and opcode 0x0F is taken when equal is clear.
- R6: Opcode 0x10 is taken when greater-than is set, and opcode 0x11 is taken when greater-than or equal is set.
- R7: Opcode 0x12 is taken when less-than is set, and opcode 0x13 is taken when less-than or equal is set.
- R8: A taken jump gives `nextPc` = `srcA` + `offset` when `directMode` is 0, and `nextPc` = `directAddr` when it is 1.
- R9: A jump that is not taken gives `nextPc` = `pc` + 4, modulo 2^32.
- R10: `resValid`, `taken` and `nextPc` are registered and appear in the cycle after a valid jump. After any other cycle, `resValid` and `taken` are 0 and `nextPc` keeps its value.
- R11: A jump issued in the cycle right after a compare is resolved against that compare's flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Opcode and operands are valid this cycle |
| opcode | input | 8 | Instruction opcode |
| srcA | input | 32 | First compare operand / jump base register |
| srcB | input | 32 | Second compare operand |
| pc | input | 32 | Address of the current instruction |
| offset | input | 32 | Offset added to base for relative targets |
| directAddr | input | 32 | Absolute jump target |
| directMode | input | 1 | 1 selects the direct target, 0 selects base plus offset |
| resValid | output | 1 | A jump resolution is presented this cycle |
| taken | output | 1 | The resolved jump is taken |
| nextPc | output | 32 | Next fetch address for the resolved jump |
| flags | output | 3 | Status: bit0 equal, bit1 greater, bit2 less |

## Verification
Every result of this block is due exactly one clock edge after the instruction is presented. The updated flags, the taken bit and the next PC all appear in the following cycle, and nothing waits longer.

The bench drives each instruction just after a falling edge and lets one rising edge pass. It advances its behavioural model at that edge and compares all four outputs at the next falling edge, before it applies the next instruction. Compares and jumps are issued back to back, so the flag dependency is exercised with no idle cycle in between.

// File: rtl/brPkg.sv
package brPkg;
  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OP_JMP = 8'h0D;
  localparam logic [OPC_W-1:0] OP_JLE = 8'h13;
  localparam logic [OPC_W-1:0] OP_CMP = 8'h14;

  // Condition order follows opcode order from OP_JMP upward
  typedef enum logic [2:0] {
    C_ALWAYS = 3'd0,
    C_EQ     = 3'd1,
    C_NE     = 3'd2,
    C_GT     = 3'd3,
    C_GE     = 3'd4,
    C_LT     = 3'd5,
    C_LE     = 3'd6
  } condSel_t;

  typedef struct packed {
    logic     cmpEn;
    logic     jmpEn;
    condSel_t cond;
  } brStrobe_t;

  localparam int FLAG_EQ = 0;
  localparam int FLAG_GT = 1;
  localparam int FLAG_LT = 2;
  localparam int FLAG_W  = 3;
endpackage

// File: rtl/brControl.sv
module brControl
  import brPkg::*;
(
  input  logic             instValid,
  input  logic [OPC_W-1:0] opcode,
  output brStrobe_t        strobe
);
  logic [OPC_W-1:0] jmpIdx;

  assign jmpIdx = opcode - OP_JMP;

  always_comb begin
    strobe       = '0;
    strobe.cond  = C_ALWAYS;
    if (instValid) begin
      if (opcode == OP_CMP) begin
        strobe.cmpEn = 1'b1;
      end else if (opcode >= OP_JMP && opcode <= OP_JLE) begin
        strobe.jmpEn = 1'b1;
        strobe.cond  = condSel_t'(jmpIdx[2:0]);
      end
    end
  end

  always_comb begin
    assert (!(strobe.cmpEn && strobe.jmpEn))
      else $error("AST_STROBE_EXCLUSIVE"); // R10
  end
endmodule

// File: rtl/brDatapath.sv
module brDatapath
  import brPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  brStrobe_t         strobe,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] pc,
  input  logic [DATA_W-1:0] offset,
  input  logic [DATA_W-1:0] directAddr,
  input  logic              directMode,
  output logic              resValid,
  output logic              taken,
  output logic [DATA_W-1:0] nextPc,
  output logic [FLAG_W-1:0] flags
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(PC_STEP);

  logic [FLAG_W-1:0] flagsQ;
  logic [FLAG_W-1:0] cmpFlags;
  logic              condMet;
  logic [DATA_W-1:0] relTarget;
  logic [DATA_W-1:0] jmpTarget;
  logic [DATA_W-1:0] fallPc;

  // Signed relational evaluation
  always_comb begin
    cmpFlags = '0;
    if (srcA == srcB)                  cmpFlags[FLAG_EQ] = 1'b1;
    else if ($signed(srcA) > $signed(srcB)) cmpFlags[FLAG_GT] = 1'b1;
    else                               cmpFlags[FLAG_LT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             flagsQ <= '0;
    else if (strobe.cmpEn) flagsQ <= cmpFlags;
  end

  always_comb begin
    unique case (strobe.cond)
      C_ALWAYS: condMet = 1'b1;
      C_EQ:     condMet = flagsQ[FLAG_EQ];
      C_NE:     condMet = !flagsQ[FLAG_EQ];
      C_GT:     condMet = flagsQ[FLAG_GT];
      C_GE:     condMet = flagsQ[FLAG_GT] | flagsQ[FLAG_EQ];
      C_LT:     condMet = flagsQ[FLAG_LT];
      C_LE:     condMet = flagsQ[FLAG_LT] | flagsQ[FLAG_EQ];
      default:  condMet = 1'b0;
    endcase
  end

  assign relTarget = srcA + offset;
  assign jmpTarget = directMode ? directAddr : relTarget;
  assign fallPc    = pc + STEP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      taken    <= 1'b0;
      nextPc   <= '0;
    end else if (strobe.jmpEn) begin
      resValid <= 1'b1;
      taken    <= condMet;
      nextPc   <= condMet ? jmpTarget : fallPc;
    end else begin
      resValid <= 1'b0;
      taken    <= 1'b0;
    end
  end

  assign flags = flagsQ;

  AST_FLAGS_ONEHOT0: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(flagsQ)); // R2
  AST_CMP_ONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmpEn |=> $countones(flagsQ) == 1); // R2
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cmpEn |=> $stable(flagsQ)); // R3
  AST_JMP_RESOLVES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.jmpEn |=> resValid); // R10
  AST_TAKEN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> resValid); // R10
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.jmpEn && !condMet |=> nextPc == $past(pc) + STEP); // R9
  AST_JMP_ALWAYS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.jmpEn && strobe.cond == C_ALWAYS |=> taken); // R4
endmodule

// File: rtl/branchResolver.sv
module branchResolver
  import brPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] pc,
  input  logic [DATA_W-1:0] offset,
  input  logic [DATA_W-1:0] directAddr,
  input  logic              directMode,
  output logic              resValid,
  output logic              taken,
  output logic [DATA_W-1:0] nextPc,
  output logic [2:0]        flags
);
  brStrobe_t strobe;

  brControl i_control (
    .instValid (instValid),
    .opcode    (opcode),
    .strobe    (strobe)
  );

  brDatapath #(.DATA_W(DATA_W)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .srcA       (srcA),
    .srcB       (srcB),
    .pc         (pc),
    .offset     (offset),
    .directAddr (directAddr),
    .directMode (directMode),
    .resValid   (resValid),
    .taken      (taken),
    .nextPc     (nextPc),
    .flags      (flags)
  );
endmodule

// File: tb/test_branchResolver.sv
module test_branchResolver;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [31:0] srcA = '0, srcB = '0, pc = '0, offset = '0, directAddr = '0;
  logic        directMode = 1'b0;
  logic        resValid, taken;
  logic [31:0] nextPc;
  logic [2:0]  flags;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state
  logic [2:0]  mFlags = '0;
  logic        mValid = 0, mTaken = 0;
  logic [31:0] mPc = '0;

  always #2.5 clk = ~clk;

  branchResolver i_branchResolver (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opcode(opcode),
    .srcA(srcA), .srcB(srcB), .pc(pc), .offset(offset),
    .directAddr(directAddr), .directMode(directMode),
    .resValid(resValid), .taken(taken), .nextPc(nextPc), .flags(flags)
  );

  function automatic bit condOk(input logic [7:0] op, input logic [2:0] f);
    case (op)
      8'h0D: return 1;
      8'h0E: return f[0];
      8'h0F: return !f[0];
      8'h10: return f[1];
      8'h11: return f[1] | f[0];
      8'h12: return f[2];
      8'h13: return f[2] | f[0];
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(input string req);
    check(req, "flags", {29'd0, flags}, {29'd0, mFlags});
    check(req, "resValid", {31'd0, resValid}, {31'd0, mValid});
    check(req, "taken", {31'd0, taken}, {31'd0, mTaken});
    check(req, "nextPc", nextPc, mPc);
  endtask

  task automatic step(input string req, input logic v, input logic [7:0] op,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] p, input logic [31:0] off,
                      input logic [31:0] da, input logic dm);
    instValid = v; opcode = op; srcA = a; srcB = b; pc = p;
    offset = off; directAddr = da; directMode = dm;
    @(posedge clk);
    if (v && op >= 8'h0D && op <= 8'h13) begin
      mValid = 1;
      mTaken = condOk(op, mFlags);
      mPc = mTaken ? (dm ? da : a + off) : p + 32'd4;
    end else begin
      mValid = 0;
      mTaken = 0;
    end
    if (v && op == 8'h14) begin
      if (a == b) mFlags = 3'b001;
      else if ($signed(a) > $signed(b)) mFlags = 3'b010;
      else mFlags = 3'b100;
    end
    @(negedge clk);
    compareAll(req);
  endtask

  task automatic cmpOp(input string req, input logic [31:0] a, input logic [31:0] b);
    step(req, 1, 8'h14, a, b, 32'h100, 0, 0, 0);
  endtask

  task automatic jmp(input string req, input logic [7:0] op, input logic dm);
    step(req, 1, op, 32'h2000, 32'h0, 32'h400, 32'h40, 32'h8000, dm);
  endtask

  initial begin
    #(5ns * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compareAll("R1 in reset");
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compareAll("R1 after reset");

    // greater-than state; R11 back-to-back compare then jump
    cmpOp("R2 gt", 32'd5, 32'd3);
    jmp("R6 R11 JGT after gt", 8'h10, 0);
    jmp("R6 JGE after gt", 8'h11, 1);
    jmp("R5 JEQ not taken R9", 8'h0E, 0);
    jmp("R5 JNE taken", 8'h0F, 0);
    jmp("R7 JLT not taken", 8'h12, 0);
    jmp("R7 JLE not taken", 8'h13, 0);
    jmp("R4 JMP relative R8", 8'h0D, 0);

    // signed: -2 < 1
    cmpOp("R2 signed lt", 32'hFFFF_FFFE, 32'd1);
    jmp("R7 R11 JLT taken", 8'h12, 1);
    jmp("R7 JLE taken", 8'h13, 0);
    jmp("R6 JGT not taken", 8'h10, 0);
    jmp("R6 JGE not taken", 8'h11, 0);
    jmp("R4 JMP direct R8", 8'h0D, 1);

    // R3: no update without a valid compare
    step("R3 cmp without valid", 0, 8'h14, 32'd9, 32'd9, 0, 0, 0, 0);
    step("R3 other opcode", 1, 8'h19, 32'd9, 32'd9, 0, 0, 0, 0);
    step("R10 jump without valid", 0, 8'h0D, 32'd9, 32'd9, 0, 0, 0, 0);
    jmp("R3 flags still lt", 8'h12, 0);

    // equal
    cmpOp("R2 eq", 32'h8000_0000, 32'h8000_0000);
    jmp("R5 R11 JEQ taken", 8'h0E, 1);
    jmp("R5 JNE not taken", 8'h0F, 0);
    jmp("R6 JGE on eq", 8'h11, 0);
    jmp("R7 JLE on eq", 8'h13, 1);
    jmp("R6 JGT not on eq", 8'h10, 0);

    // signed: large positive > negative
    cmpOp("R2 signed gt", 32'h7FFF_FFFF, 32'h8000_0000);
    step("R9 wrap", 1, 8'h12, 0, 0, 32'hFFFF_FFFC, 32'h4, 32'h10, 0);
    step("R8 relative wrap", 1, 8'h10, 32'hFFFF_FFF0, 0, 0, 32'h20, 0, 0);
    step("R10 idle after jump", 0, 8'h00, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule